// File: doc/BRIEF.md
# Set/Clear/Toggle Register Bank

A bank of 32-bit control registers on a simple synchronous register bus. Each register sits in its own 16-byte address window, and the four word addresses inside that window are aliases of the same register. A write through the first alias replaces the value. A write through each of the other three aliases sets, clears or inverts the bits that are 1 in the write data. Each of these is a read-modify-write that completes in one cycle inside the bank, so software can change single bits without first reading the register.

Every register's current value is also driven on a flat parallel output that feeds downstream clock-control logic. Reads are registered and return data one cycle after the read enable. Misaligned accesses and accesses past the last register have no effect on the bank. A misaligned access also raises a one-cycle error flag.

Top module: `sct_regbank`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every register, the read data and the error flag are zero.
- R2: Register k occupies byte addresses 16k to 16k+15. Its index is address bits [ADDR_W-1:4] and the operation is address bits [3:2]. Operation 00 (offset 0x0) loads the write data into the register unchanged.
- R3: Operation 01 (offset 0x4) ORs the write data into the register.
- R4: Operation 10 (offset 0x8) clears the register bits that are 1 in the write data.
- R5: Operation 11 (offset 0xC) XORs the write data into the register.
- R6: A read through any of the four aliases returns the register's value on bus_rdata in the cycle after the read enable. In the cycle after any cycle with no valid read, bus_rdata is zero.
- R7: An access with address bits [1:0] not equal to 00 is misaligned. A misaligned write changes no register, a misaligned read returns zero, and bus_err is high for exactly the cycle after the access.
- R8: An aligned access whose index is NUM_REGS or greater changes no register, returns zero on a read, and does not raise bus_err.
- R9: The result of a write appears on regs_out in the cycle after the write. With no write, regs_out does not change.
- R10: A read and a write to the same register in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | One-cycle misaligned-access flag |
| regs_out | output | NUM_REGS*DATA_W | All registers, register k at bits [k*DATA_W +: DATA_W] |

## Verification
The assertions check the properties that hold on every cycle: the reset values, that regs_out stays still when there is no write, when a write is misaligned and when a write is out of range, that bus_err is only ever caused by a misaligned access, and that bus_rdata is zero after an idle or out-of-range read. The exact results of the set, clear and toggle aliases, reads through every alias, and a read and write to the same register in one cycle can only be shown by the bench's scenarios. There, a behavioural model follows every cycle and is compared against the outputs.

// File: rtl/sct_regbank.sv
module sct_regbank #(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_we,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic                       bus_re,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       bus_err,
  output logic [NUM_REGS*DATA_W-1:0] regs_out
);
  localparam int IDX_W = ADDR_W - 4;
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_REGS);

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;

  wire [IDX_W-1:0] idx     = bus_addr[ADDR_W-1:4];
  wire [1:0]       op      = bus_addr[3:2];
  wire             aligned = (bus_addr[1:0] == 2'b00);
  wire             hit     = aligned && ({1'b0, idx} < LIMIT);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    wire sel = bus_we && hit && (idx == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[k] <= '0;
      else if (sel)
        case (op)
          2'b00:   regs_q[k] <= bus_wdata;
          2'b01:   regs_q[k] <= regs_q[k] | bus_wdata;
          2'b10:   regs_q[k] <= regs_q[k] & ~bus_wdata;
          default: regs_q[k] <= regs_q[k] ^ bus_wdata;
        endcase
    end
    assign regs_out[k*DATA_W +: DATA_W] = regs_q[k];
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (idx == IDX_W'(k)) rd_word = regs_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= (bus_re && hit) ? rd_word : '0;
      err_q   <= (bus_we || bus_re) && !aligned;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
endmodule

// File: rtl/sct_regbank_chk.sv
module sct_regbank_chk #(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_we,
  input logic                       bus_re,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic                       bus_err,
  input logic [NUM_REGS*DATA_W-1:0] regs_out
);
  localparam int IDX_W = ADDR_W - 4;
  wire oob = ({1'b0, bus_addr[ADDR_W-1:4]} >= (IDX_W+1)'(NUM_REGS));
  wire mis = (bus_addr[1:0] != 2'b00);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (regs_out == '0 && bus_rdata == '0 && !bus_err));

  a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past((bus_we || bus_re) && mis));

  a_r7_misaligned_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && mis) |=> $stable(regs_out));

  a_r8_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && oob) |=> $stable(regs_out));

  a_r8_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && oob && !mis) |=> (bus_rdata == '0 && !bus_err));

  a_r9_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(regs_out));

  a_r6_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> (bus_rdata == '0));
endmodule

bind sct_regbank sct_regbank_chk #(
  .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_re(bus_re), .bus_rdata(bus_rdata), .bus_err(bus_err), .regs_out(regs_out)
);

// File: tb/sct_regbank_bench.sv
module sct_regbank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_REGS = 8;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic bus_err;
  logic [NUM_REGS*DATA_W-1:0] regs_out;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  logic [DATA_W-1:0] model [NUM_REGS];
  logic [DATA_W-1:0] exp_rd;
  logic exp_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  sct_regbank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sct_regbank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .regs_out(regs_out));

  task automatic check(string tag, string what, logic [NUM_REGS*DATA_W-1:0] act,
                       logic [NUM_REGS*DATA_W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    logic [NUM_REGS*DATA_W-1:0] flat;
    for (int k = 0; k < NUM_REGS; k++) flat[k*DATA_W +: DATA_W] = model[k];
    check(tag, "regs_out", regs_out, flat);
    check(tag, "rdata", {{(NUM_REGS-1)*DATA_W{1'b0}}, bus_rdata},
          {{(NUM_REGS-1)*DATA_W{1'b0}}, exp_rd});
    check(tag, "err", {{(NUM_REGS*DATA_W-1){1'b0}}, bus_err},
          {{(NUM_REGS*DATA_W-1){1'b0}}, exp_err});
  endtask

  task automatic step(string tag, bit we, bit re, int addr, logic [DATA_W-1:0] wd);
    int idx = addr >> 4;
    int op = (addr >> 2) & 3;
    bit al = (addr & 3) == 0;
    bit inr = idx < NUM_REGS;
    bus_we = we; bus_re = re; bus_addr = ADDR_W'(addr); bus_wdata = wd;
    exp_rd = (re && al && inr) ? model[idx] : '0;
    exp_err = (we || re) && !al;
    if (we && al && inr)
      case (op)
        0: model[idx] = wd;
        1: model[idx] = model[idx] | wd;
        2: model[idx] = model[idx] & ~wd;
        default: model[idx] = model[idx] ^ wd;
      endcase
    @(posedge clk);
    @(negedge clk);
    bus_we = 0; bus_re = 0;
    compare_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NUM_REGS; k++) model[k] = '0;
    exp_rd = '0; exp_err = 0;
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    compare_all("R1 after reset");

    for (int k = 0; k < NUM_REGS; k++)
      step("R2 plain write", 1, 0, 16*k, 32'hA5000000 + 32'(k * 32'h1111));
    for (int k = 0; k < NUM_REGS; k++)
      step("R6 read alias", 0, 1, 16*k + 4*(k % 4), '0);
    step("R6 idle after read", 0, 0, 0, '0);

    step("R3 set", 1, 0, 16*2 + 4, 32'h0000_00FF);
    step("R3 set readback", 0, 1, 16*2 + 8, '0);
    step("R4 clear", 1, 0, 16*3 + 8, 32'hFFFF_0000);
    step("R4 clear readback", 0, 1, 16*3 + 12, '0);
    step("R5 toggle", 1, 0, 16*4 + 12, 32'hF0F0_F0F0);
    step("R5 toggle again", 1, 0, 16*4 + 12, 32'h0FF0_0001);
    step("R5 toggle readback", 0, 1, 16*4, '0);
    step("R2 overwrite zero", 1, 0, 16*7, 32'h0);

    step("R7 misaligned write", 1, 0, 16*1 + 1, 32'hDEAD_BEEF);
    step("R7 misaligned read", 0, 1, 16*1 + 6, '0);
    step("R7 err drops", 0, 1, 16*1, '0);
    step("R7 misaligned toggle", 1, 0, 16*5 + 15, 32'hFFFF_FFFF);

    step("R8 oob write", 1, 0, 16*NUM_REGS, 32'h1234_5678);
    step("R8 oob set", 1, 0, 16*15 + 4, 32'hFFFF_FFFF);
    step("R8 oob read", 0, 1, 16*NUM_REGS + 8, '0);

    step("R10 read and write same reg", 1, 1, 16*6, 32'h5555_AAAA);
    step("R10 new value read", 0, 1, 16*6 + 4, '0);
    step("R10 read and clear same reg", 1, 1, 16*6 + 8, 32'h0000_FFFF);
    step("R9 idle", 0, 0, 0, '0);
    step("R9 idle read", 0, 1, 16*6, '0);

    for (int n = 0; n < 40; n++)
      step("R9 mixed", (n % 3) != 0, (n % 2) == 0, (n * 37) & 8'h7C, 32'(n * 32'h9E3779B1));

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule